// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit sits between a 32-bit word-addressed register bus and the transfer engine of an SPI controller. It owns the transmit and receive FIFOs, which have the same depth. It turns their occupancy into a set of live status flags. It also keeps two sticky event flags: receive overflow, and transfer complete. A single level-sensitive interrupt line is driven from the status bits that software has enabled. The unit decides which data-port accesses take effect. It also gives the software reset that clearing the enable bit performs.

The engine drains transmit words through a pop request and sees each word on the next cycle. It pushes received words through a push request. When a transfer finishes it raises a one-cycle done pulse. Software reaches everything through five registers at word addresses 0 to 4. A bus read returns its data one clock after the request is sampled.

Top module: `spi_fifo_status_irq`

## Requirements
- R1: After the synchronous reset, the status register (address 4) reads 0x00000003. The control (address 2) and interrupt-enable (address 3) registers read 0, and irq is low.
- R2: Status bit 0 is 1 exactly when the TX FIFO is empty. Bit 2 is 1 exactly when it holds DEPTH words. Bit 1 is 1 when it holds at most TX_MARK words.
- R3: Status bit 3 is 1 when the RX FIFO is not empty. Bit 5 is 1 when it holds DEPTH words. Bit 4 is 1 when it holds more than RX_MARK words.
- R4: A push or pop moves the FIFO occupancy at the edge where it is sampled. The live flags (bits 5..0) follow at the next edge.
- R5: A push request from the engine while the RX FIFO is full drops the word and sets status bit 6, which stays set.
- R6: A done pulse sets status bit 7, which stays set.
- R7: A write to the status register clears bit 6 and/or bit 7 where the written bit is 1. It changes no other bit. If a set event and a clear arrive in the same cycle, the set wins.
- R8: irq is high exactly when status[7:0] AND interrupt-enable[7:0] is non-zero.
- R9: A control write with bit 0 (enable) equal to 0 empties both FIFOs and zeroes the control and interrupt-enable registers. It also clears the sticky bits, so status reads 0x00000003 again.
- R10: A read of address 0 returns 0 and pops nothing while enable is 0. With enable at 1 it returns 0xDEADBEEF if the RX FIFO is empty, and otherwise it pops and returns the oldest received word.
- R11: A write to address 1 is dropped while enable is 0 or the TX FIFO is full. Accepted words reach the engine in write order. A read of address 1 returns 0.
- R12: Addresses 2 and 3 read back the last value written. Addresses 5 to 7 read 0 and ignore writes. Read data appears one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| eng_tx_pop | input | 1 | Engine takes one TX word |
| eng_tx_data | output | DATA_W | Word popped by the previous eng_tx_pop |
| eng_tx_empty | output | 1 | TX FIFO holds no word |
| eng_rx_push | input | 1 | Engine delivers one received word |
| eng_rx_data | input | DATA_W | Received word |
| eng_xfer_done | input | 1 | One-cycle transfer-complete pulse |
| ctrl | output | DATA_W | Control register contents, for the engine |
| irq | output | 1 | Level interrupt |

## Verification
The bench probes both watermark edges, full FIFOs and pushes past full. A design with an off-by-one compare would set the data-request flags one word early. A design that lets a push into a full FIFO through would overwrite the oldest word, so the out-of-order data shows at the engine or bus side. Clearing a sticky bit with a write of all ones must leave the live flags alone, and a wrong mask would drop or clear them. Soft reset issued with data still queued must leave both FIFOs empty, and a design that missed one FIFO would give up stale words after re-enable. Random traffic mixes engine pushes with bus pops in the same cycle. It also catches a design that samples full or empty after the other side has moved, or that lets the interrupt lag its enable.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
  typedef enum logic [2:0] {
    A_RXD  = 3'd0,
    A_TXD  = 3'd1,
    A_CTRL = 3'd2,
    A_IEN  = 3'd3,
    A_STAT = 3'd4
  } reg_addr_e;

  localparam int STAT_W = 8;
  localparam int B_TE   = 0;
  localparam int B_TDR  = 1;
  localparam int B_TF   = 2;
  localparam int B_RR   = 3;
  localparam int B_RDR  = 4;
  localparam int B_RF   = 5;
  localparam int B_OVF  = 6;
  localparam int B_TC   = 7;
  localparam int N_LIVE = 6;
  localparam int N_STICKY = 2;

  localparam logic [STAT_W-1:0] STAT_RST  = 8'h03;
  localparam logic [STAT_W-1:0] STAT_W1C  = 8'hC0;
  localparam logic [31:0]       RX_NODATA = 32'hDEAD_BEEF;
  localparam int CTRL_EN = 0;
endpackage

// File: rtl/sfi_fifo.sv
module sfi_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (do_pop) dout <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R11: a push into a full FIFO with no pop leaves the occupancy unchanged
  p_full_hold_r11: assert property (@(posedge clk) disable iff (clr)
    push && full && !pop |=> count == $past(count));

  // R10: a pop from an empty FIFO with no push leaves the occupancy unchanged
  p_empty_hold_r10: assert property (@(posedge clk) disable iff (clr)
    pop && empty && !push |=> count == $past(count));
endmodule

// File: rtl/sfi_status.sv
module sfi_status
  import sfi_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int TX_MARK = DEPTH / 2,
  parameter int RX_MARK = DEPTH / 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [CW-1:0]     tx_count,
  input  logic              tx_empty,
  input  logic              tx_full,
  input  logic [CW-1:0]     rx_count,
  input  logic              rx_empty,
  input  logic              rx_full,
  input  logic              rx_push,
  input  logic              xfer_done,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic [STAT_W-1:0] ien,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  logic [N_LIVE-1:0]   live_d, live_q;
  logic [N_STICKY-1:0] stk_set;
  logic                wipe;

  assign wipe = rst | soft_rst;

  always_comb begin
    live_d        = '0;
    live_d[B_TE]  = tx_empty;
    live_d[B_TDR] = (tx_count <= CW'(TX_MARK));
    live_d[B_TF]  = tx_full;
    live_d[B_RR]  = ~rx_empty;
    live_d[B_RDR] = (rx_count > CW'(RX_MARK));
    live_d[B_RF]  = rx_full;
  end

  always_ff @(posedge clk) begin
    if (wipe) live_q <= STAT_RST[N_LIVE-1:0];
    else      live_q <= live_d;
  end

  assign stat[N_LIVE-1:0] = live_q;

  // sticky set sources, indexed from B_OVF upward
  assign stk_set[0] = rx_push & rx_full;
  assign stk_set[1] = xfer_done;

  for (genvar g = 0; g < N_STICKY; g++) begin : g_stk
    logic q;
    always_ff @(posedge clk) begin
      if (wipe) q <= STAT_RST[B_OVF + g];
      else      q <= stk_set[g] | (q & ~clr_mask[B_OVF + g]);
    end
    assign stat[B_OVF + g] = q;
  end

  assign irq = |(stat & ien);

  // R5: a push into a full RX FIFO raises the overflow flag
  p_ovf_set_r5: assert property (@(posedge clk) disable iff (rst)
    !soft_rst && rx_push && rx_full |=> stat[B_OVF]);

  // R6: a done pulse raises the completion flag
  p_tc_set_r6: assert property (@(posedge clk) disable iff (rst)
    !soft_rst && xfer_done |=> stat[B_TC]);

  // R7: without a clear, the sticky flags hold
  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !soft_rst && stat[B_OVF] && !clr_mask[B_OVF] |=> stat[B_OVF]);
  p_tc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !soft_rst && stat[B_TC] && !clr_mask[B_TC] |=> stat[B_TC]);
endmodule

// File: rtl/sfi_regif.sv
module sfi_regif
  import sfi_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [STAT_W-1:0] stat,
  input  logic              tx_full,
  input  logic              rx_empty,
  input  logic [DATA_W-1:0] rx_dout,
  output logic              soft_rst,
  output logic              tx_push,
  output logic              rx_pop,
  output logic [STAT_W-1:0] clr_mask,
  output logic [DATA_W-1:0] ctrl,
  output logic [DATA_W-1:0] ien
);
  logic              wr_en, rd_en, enabled, from_fifo_q;
  logic              hit_rxd, hit_txd, hit_ctrl, hit_ien, hit_stat;
  logic [DATA_W-1:0] ctrl_q, ien_q, rdata_q, rd_val;

  assign wr_en    = bus_sel & bus_wr;
  assign rd_en    = bus_sel & ~bus_wr;
  assign enabled  = ctrl_q[CTRL_EN];
  assign hit_rxd  = (bus_addr == ADDR_W'(A_RXD));
  assign hit_txd  = (bus_addr == ADDR_W'(A_TXD));
  assign hit_ctrl = (bus_addr == ADDR_W'(A_CTRL));
  assign hit_ien  = (bus_addr == ADDR_W'(A_IEN));
  assign hit_stat = (bus_addr == ADDR_W'(A_STAT));

  assign soft_rst = wr_en & hit_ctrl & ~bus_wdata[CTRL_EN];
  assign tx_push  = wr_en & hit_txd & enabled & ~tx_full;
  assign rx_pop   = rd_en & hit_rxd & enabled & ~rx_empty;
  assign clr_mask = (wr_en & hit_stat) ? (bus_wdata[STAT_W-1:0] & STAT_W1C) : '0;

  always_comb begin
    rd_val = '0;
    if (hit_rxd && enabled && rx_empty) rd_val = DATA_W'(RX_NODATA);
    else if (hit_ctrl)                  rd_val = ctrl_q;
    else if (hit_ien)                   rd_val = ien_q;
    else if (hit_stat)                  rd_val = DATA_W'(stat);
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ctrl_q      <= '0;
      ien_q       <= '0;
      rdata_q     <= '0;
      from_fifo_q <= 1'b0;
    end else begin
      from_fifo_q <= rx_pop;
      if (rd_en)            rdata_q <= rd_val;
      if (wr_en && hit_ctrl) ctrl_q <= bus_wdata;
      if (wr_en && hit_ien)  ien_q  <= bus_wdata;
    end
  end

  assign bus_rdata = from_fifo_q ? rx_dout : rdata_q;
  assign ctrl      = ctrl_q;
  assign ien       = ien_q;

  // R10: a receive-port read while disabled returns zero
  p_rx_disabled_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en && hit_rxd && !enabled |=> bus_rdata == '0);

  // R9: software reset leaves control and enable registers cleared
  p_soft_clear_r9: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> ctrl_q == '0 && ien_q == '0);
endmodule

// File: rtl/spi_fifo_status_irq.sv
module spi_fifo_status_irq
  import sfi_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 64,
  parameter int TX_MARK = DEPTH / 2,
  parameter int RX_MARK = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_tx_pop,
  output logic [DATA_W-1:0] eng_tx_data,
  output logic              eng_tx_empty,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic              eng_xfer_done,
  output logic [DATA_W-1:0] ctrl,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic              soft_rst, fifo_clr, tx_push, rx_pop;
  logic [CW-1:0]     tx_count, rx_count;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [DATA_W-1:0] rx_dout, ien;
  logic [STAT_W-1:0] stat, clr_mask;

  assign fifo_clr     = rst | soft_rst;
  assign eng_tx_empty = tx_empty;

  sfi_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stat(stat), .tx_full(tx_full), .rx_empty(rx_empty), .rx_dout(rx_dout),
    .soft_rst(soft_rst), .tx_push(tx_push), .rx_pop(rx_pop),
    .clr_mask(clr_mask), .ctrl(ctrl), .ien(ien)
  );

  sfi_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .clr(fifo_clr),
    .push(tx_push), .din(bus_wdata),
    .pop(eng_tx_pop), .dout(eng_tx_data),
    .count(tx_count), .empty(tx_empty), .full(tx_full)
  );

  sfi_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .clr(fifo_clr),
    .push(eng_rx_push), .din(eng_rx_data),
    .pop(rx_pop), .dout(rx_dout),
    .count(rx_count), .empty(rx_empty), .full(rx_full)
  );

  sfi_status #(.DEPTH(DEPTH), .TX_MARK(TX_MARK), .RX_MARK(RX_MARK)) u_status (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .tx_count(tx_count), .tx_empty(tx_empty), .tx_full(tx_full),
    .rx_count(rx_count), .rx_empty(rx_empty), .rx_full(rx_full),
    .rx_push(eng_rx_push), .xfer_done(eng_xfer_done),
    .clr_mask(clr_mask), .ien(ien[STAT_W-1:0]),
    .stat(stat), .irq(irq)
  );

  // R11: a transmit-port write while disabled leaves the TX FIFO untouched
  p_tx_disabled_r11: assert property (@(posedge clk) disable iff (rst)
    bus_sel && bus_wr && bus_addr == ADDR_W'(A_TXD) && !ctrl[CTRL_EN] && !eng_tx_pop
    |=> tx_count == $past(tx_count));
endmodule

// File: tb/spi_fifo_status_irq_bench.sv
`timescale 1ns/1ps
module spi_fifo_status_irq_bench;
  localparam int DEPTH   = 64;
  localparam int TX_MARK = DEPTH / 2;
  localparam int RX_MARK = DEPTH / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, eng_tx_data, eng_rx_data = '0, ctrl;
  logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0, eng_xfer_done = 1'b0;
  logic        eng_tx_empty, irq;

  always #2 clk = ~clk;

  spi_fifo_status_irq u_spi_fifo_status_irq (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_empty(eng_tx_empty),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .eng_xfer_done(eng_xfer_done), .ctrl(ctrl), .irq(irq)
  );

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] txq[$], rxq[$];
  logic [31:0] m_ctrl, m_ien, rd_e, txd_e;
  logic [7:0]  m_stat, live, clr;
  bit          rd_v, txd_v, m_en, ovf, tc;
  string       rd_tag;
  int          tn, rn;

  always @(posedge clk) begin
    if (rst) begin
      txq.delete(); rxq.delete();
      m_ctrl = 0; m_ien = 0; m_stat = 8'h03; rd_v = 0; txd_v = 0;
    end else begin
      tn = txq.size(); rn = rxq.size(); m_en = m_ctrl[0];
      live = {2'b00, rn == DEPTH, rn > RX_MARK, rn != 0, tn == DEPTH, tn <= TX_MARK, tn == 0};
      if (bus_sel && !bus_wr) begin
        rd_v = 1;
        case (bus_addr)
          3'd0: begin
            rd_tag = "R10";
            if (!m_en) rd_e = 0;
            else if (rn == 0) rd_e = 32'hDEADBEEF;
            else rd_e = rxq.pop_front();
          end
          3'd1: begin rd_tag = "R11"; rd_e = 0; end
          3'd2: begin rd_tag = "R12"; rd_e = m_ctrl; end
          3'd3: begin rd_tag = "R12"; rd_e = m_ien; end
          3'd4: begin rd_tag = "R2/R3/R4/R5/R6/R7"; rd_e = {24'h0, m_stat}; end
          default: begin rd_tag = "R12"; rd_e = 0; end
        endcase
      end
      if (bus_sel && bus_wr && bus_addr == 3'd2 && !bus_wdata[0]) begin
        txq.delete(); rxq.delete();            // R9 soft reset
        m_ctrl = 0; m_ien = 0; m_stat = 8'h03;
      end else begin
        clr = (bus_sel && bus_wr && bus_addr == 3'd4) ? (bus_wdata[7:0] & 8'hC0) : 8'h00;
        ovf = (m_stat[6] & ~clr[6]) | (eng_rx_push && rn == DEPTH);
        tc  = (m_stat[7] & ~clr[7]) | eng_xfer_done;
        if (eng_tx_pop && tn != 0) begin txd_e = txq.pop_front(); txd_v = 1; end
        if (bus_sel && bus_wr && bus_addr == 3'd1 && m_en && tn < DEPTH) txq.push_back(bus_wdata);
        if (eng_rx_push && rn < DEPTH) rxq.push_back(eng_rx_data);
        if (bus_sel && bus_wr && bus_addr == 3'd2) m_ctrl = bus_wdata;
        if (bus_sel && bus_wr && bus_addr == 3'd3) m_ien = bus_wdata;
        m_stat = {tc, ovf, live[5:0]};
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      chk(irq === (|(m_stat & m_ien[7:0])), "R8", {31'h0, irq}, {31'h0, |(m_stat & m_ien[7:0])});
      if (rd_v) begin
        chk(bus_rdata === rd_e, rd_tag, bus_rdata, rd_e);
        rd_v = 0;
      end
      if (txd_v) begin
        chk(eng_tx_data === txd_e, "R11", eng_tx_data, txd_e);
        txd_v = 0;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input bit s, input bit w, input logic [2:0] a, input logic [31:0] d,
                      input bit tp, input bit rp, input logic [31:0] rd, input bit dn);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    eng_tx_pop = tp; eng_rx_push = rp; eng_rx_data = rd; eng_xfer_done = dn;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(1, 1, a, d, 0, 0, 0, 0);
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    step(1, 0, a, 0, 0, 0, 0, 0);
    idle(1);
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset values
    rd_chk(3'd4, 32'h03, "R1");
    rd_chk(3'd2, 32'h00, "R1");
    rd_chk(3'd3, 32'h00, "R1");
    chk(irq === 1'b0, "R1", {31'h0, irq}, 32'h0);
    // R11 write while disabled is dropped; R10 read while disabled
    wr(3'd1, 32'hAAAA_0001);
    idle(2);
    rd_chk(3'd4, 32'h03, "R11");
    rd_chk(3'd0, 32'h00, "R10");
    rd_chk(3'd1, 32'h00, "R11");
    // enable
    wr(3'd2, 32'h0000_0001);
    wr(3'd1, 32'h11); wr(3'd1, 32'h22); wr(3'd1, 32'h33);
    idle(2);
    rd_chk(3'd4, 32'h02, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, 0, 0);
    idle(2);
    // R2 fill TX FIFO, two extra words dropped
    for (int i = 0; i < DEPTH + 2; i++) wr(3'd1, 32'h1000 + i);
    idle(2);
    rd_chk(3'd4, 32'h04, "R2");
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 0, 1, 0, 0, 0);
    idle(2);
    rd_chk(3'd4, 32'h03, "R2");
    // R3 RX watermark and full
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 0, 1, 32'h2000 + i, 0);
    idle(2);
    rd_chk(3'd4, 32'h1B, "R3");
    for (int i = 40; i < DEPTH; i++) step(0, 0, 0, 0, 0, 1, 32'h2000 + i, 0);
    idle(2);
    rd_chk(3'd4, 32'h3B, "R3");
    // R5 push past full
    step(0, 0, 0, 0, 0, 1, 32'hBAD0_0000, 0);
    idle(2);
    rd_chk(3'd4, 32'h7B, "R5");
    rd_chk(3'd0, 32'h2000, "R10");
    // R7 write ones clears only the sticky bits
    wr(3'd4, 32'hFFFF_FFFF);
    idle(2);
    rd_chk(3'd4, 32'h1B, "R7");
    // R6 done pulse
    step(0, 0, 0, 0, 0, 0, 0, 1);
    idle(2);
    rd_chk(3'd4, 32'h9B, "R6");
    wr(3'd3, 32'h80);
    idle(1);
    chk(irq === 1'b1, "R8", {31'h0, irq}, 32'h1);
    wr(3'd4, 32'h80);
    idle(1);
    chk(irq === 1'b0, "R8", {31'h0, irq}, 32'h0);
    wr(3'd3, 32'h01);
    idle(1);
    chk(irq === 1'b1, "R8", {31'h0, irq}, 32'h1);
    // R9 soft reset with RX data queued and TX data queued
    wr(3'd1, 32'h5555);
    wr(3'd2, 32'h0000_00F0);
    idle(2);
    rd_chk(3'd4, 32'h03, "R9");
    rd_chk(3'd3, 32'h00, "R9");
    rd_chk(3'd2, 32'h00, "R9");
    chk(irq === 1'b0, "R9", {31'h0, irq}, 32'h0);
    rd_chk(3'd0, 32'h00, "R10");
    wr(3'd2, 32'h0000_0001);
    rd_chk(3'd0, 32'hDEAD_BEEF, "R10");
    chk(eng_tx_empty === 1'b1, "R9", {31'h0, eng_tx_empty}, 32'h1);
    rd_chk(3'd6, 32'h00, "R12");
    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit s, w;
      logic [2:0] a;
      logic [31:0] d;
      r = $urandom_range(0, 99);
      s = 1; w = 0; a = 0; d = $urandom;
      if (r < 20)      begin w = 1; a = 3'd1; end
      else if (r < 36) begin a = 3'd0; end
      else if (r < 42) begin a = 3'd4; end
      else if (r < 45) begin w = 1; a = 3'd3; d = d & 32'hFF; end
      else if (r < 47) begin w = 1; a = 3'd4; end
      else if (r < 49) begin w = 1; a = 3'd2; d[0] = 1'b1; end
      else if (r == 49) begin w = 1; a = 3'd2; d[0] = 1'b0; end
      else if (r < 53) begin a = 3'($urandom_range(0, 7)); end
      else if (r < 55) begin w = 1; a = 3'($urandom_range(5, 7)); end
      else s = 0;
      step(s, w, a, d, $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0,
           $urandom, $urandom_range(0, 30) == 0);
    end
    idle(4);
    finish_run();
  end
endmodule